// File: doc/BRIEF.md
# Synchronous Flow-Through Byte-Write Static Memory

A clocked static memory of 72-bit words. Each word is eight byte lanes of eight data bits plus one parity bit. The address, write data, parity, byte strobes, chip enables and address-status strobe are all sampled on the rising clock edge. The output enables are not sampled.

On each edge the address-status strobe (`ads_n`) and the chip enables choose one of three outcomes for each of the two banks:
- **Start:** an access starts at the address on the pins.
- **Continue:** the access in progress continues at the address the bank already holds.
- **Deselect:** the bank is deselected.

The top address bit picks the bank. Each bank has its own chip enable and output enable. A cycle with any byte strobe low is a write. A cycle with every byte strobe high is a read.

Reads are flow-through. After the edge that registers a read, the addressed word reaches the read bus through combinational logic, during that same clock period. The bus is shown as `rd_drive`, the tristate driver enable, together with the data values. When the bus is not driven, the data values are forced to zero. The data and parity pins carry no handshake: every edge is one access slot, so there is no back-pressure.

Top module: `sync_ft_sram`

## Requirements
- R1: After reset both banks are deselected. `rd_drive` stays 0 until a start cycle. Continue cycles with byte strobes low write nothing while a bank is deselected. Reset leaves the stored words unchanged.
- R2: An edge with `ads_n`=0 deselects every bank whose `ce_n` bit is 1 or whose index differs from `addr[ADDR_W-1]`. A deselected bank never drives and never writes.
- R3: An edge with `ads_n`=0, `ce_n[b]`=0, `addr[ADDR_W-1]`=b and `bw_n` all ones starts a read of bank b at the low address bits. In the following clock period, while `oe_n[b]`=0, `rd_drive`=1 and `rdata`/`rpar` carry the stored word.
- R4: The same start with any `bw_n` bit at 0 is a write at that edge. In the following period `rd_drive`=0 whatever the `oe_n` level.
- R5: An edge with `ads_n`=1 continues the active bank at its held address, ignoring `addr` and `ce_n`. The access is a write if any `bw_n` bit is 0, otherwise a read.
- R6: An edge with `ads_n`=1 leaves a deselected bank deselected.
- R7: `rd_drive` follows `oe_n` of the reading bank within the clock period, with no clock edge. When `rd_drive`=0, `rdata` and `rpar` are zero.
- R8: Written data is stored on the edge of the write cycle. A read of the same address registered on the next edge returns the new word.
- R9: The two banks hold separate words. The same low address in bank 0 and in bank 1 refers to different storage. At most one bank is active at a time.
- R10: Lane k is `wdata[8k+7:8k]` with parity `wpar[k]` and is written only when `bw_n[k]`=0. Lanes whose strobe is high keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of control state |
| addr | input | ADDR_W | Word address; the top bit selects the bank |
| ads_n | input | 1 | Address-status strobe, low selects start or deselect |
| ce_n | input | 2 | Active-low chip enable per bank |
| oe_n | input | 2 | Active-low asynchronous output enable per bank |
| bw_n | input | LANES | Active-low byte-lane write strobes |
| wdata | input | LANES*8 | Write data |
| wpar | input | LANES | Write parity, one bit per lane |
| rdata | output | LANES*8 | Read data, zero when not driven |
| rpar | output | LANES | Read parity, zero when not driven |
| rd_drive | output | 1 | Read bus driver enable |

## Verification
Every registered result is due in the clock period right after the edge that samples the stimulus. This covers the cycle type, the held address, the stored word and the driven read data. The bench applies inputs on the falling edge, updates its reference model at the rising edge, and compares one time unit later on every clock. Output-enable effects take no clock at all. For these, the bench changes `oe_n` in the middle of a period and checks `rd_drive` and the data a moment later, with no edge in between. A write is checked through a read registered on the following edge.

// File: rtl/sram_ft_pkg.sv
package sram_ft_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_e;
endpackage

// File: rtl/sram_ft_ctrl.sv
module sram_ft_ctrl
  import sram_ft_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LANES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ads_n,
  input  logic             ce_n,
  input  logic             sel,
  input  logic [AW-1:0]    addr,
  input  logic [LANES-1:0] bw_n,
  output cyc_e             cyc,
  output logic [AW-1:0]    held_addr,
  output logic [LANES-1:0] wr_en,
  output logic [AW-1:0]    wr_addr
);
  logic          start_acc;
  logic          any_wr;
  logic          act_next;
  logic [AW-1:0] addr_next;
  cyc_e          cyc_q, cyc_d;
  logic [AW-1:0] addr_q;

  always_comb begin
    start_acc = !ads_n && !ce_n && sel;
    any_wr    = ~&bw_n;
    if (!ads_n) act_next = start_acc;
    else        act_next = (cyc_q != CYC_IDLE);
    addr_next = start_acc ? addr : addr_q;
    if (!act_next)   cyc_d = CYC_IDLE;
    else if (any_wr) cyc_d = CYC_WRITE;
    else             cyc_d = CYC_READ;
  end

  assign wr_en   = act_next ? ~bw_n : '0;
  assign wr_addr = addr_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= CYC_IDLE;
      addr_q <= '0;
    end else begin
      cyc_q  <= cyc_d;
      addr_q <= addr_next;
    end
  end

  assign cyc       = cyc_q;
  assign held_addr = addr_q;

  // R2
  desel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ads_n && (ce_n || !sel)) |=> (cyc == CYC_IDLE));
  // R6
  stay_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ads_n && cyc == CYC_IDLE) |=> (cyc == CYC_IDLE));
  // R5
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ads_n |=> (held_addr == $past(held_addr)));
  // R5
  cont_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ads_n && cyc != CYC_IDLE && !(&bw_n)) |=> (cyc == CYC_WRITE));
endmodule

// File: rtl/sram_ft_lane.sv
module sram_ft_lane #(
  parameter int AW = 8,
  parameter int W  = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rd
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wd;
  end

  assign rd = mem[raddr];
endmodule

// File: rtl/sram_ft_bank.sv
module sram_ft_bank
  import sram_ft_pkg::*;
#(
  parameter int AW     = 8,
  parameter int LANES  = 8,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ads_n,
  input  logic                    ce_n,
  input  logic                    sel,
  input  logic [AW-1:0]           addr,
  input  logic [LANES-1:0]        bw_n,
  input  logic [LANES*BYTE_W-1:0] wdata,
  input  logic [LANES-1:0]        wpar,
  output cyc_e                    cyc,
  output logic [LANES*BYTE_W-1:0] rdata,
  output logic [LANES-1:0]        rpar
);
  localparam int LW = BYTE_W + 1;

  logic [AW-1:0]    held_addr;
  logic [LANES-1:0] wr_en;
  logic [AW-1:0]    wr_addr;

  sram_ft_ctrl #(.AW(AW), .LANES(LANES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ads_n     (ads_n),
    .ce_n      (ce_n),
    .sel       (sel),
    .addr      (addr),
    .bw_n      (bw_n),
    .cyc       (cyc),
    .held_addr (held_addr),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LW-1:0] lane_rd;
    sram_ft_lane #(.AW(AW), .W(LW)) u_lane (
      .clk   (clk),
      .we    (wr_en[k]),
      .waddr (wr_addr),
      .wd    ({wpar[k], wdata[k*BYTE_W +: BYTE_W]}),
      .raddr (held_addr),
      .rd    (lane_rd)
    );
    assign rdata[k*BYTE_W +: BYTE_W] = lane_rd[BYTE_W-1:0];
    assign rpar[k]                   = lane_rd[BYTE_W];
  end
endmodule

// File: rtl/sync_ft_sram.sv
module sync_ft_sram
  import sram_ft_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int LANES  = 8,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    ads_n,
  input  logic [1:0]              ce_n,
  input  logic [1:0]              oe_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic [LANES*BYTE_W-1:0] wdata,
  input  logic [LANES-1:0]        wpar,
  output logic [LANES*BYTE_W-1:0] rdata,
  output logic [LANES-1:0]        rpar,
  output logic                    rd_drive
);
  localparam int BANKS = 2;
  localparam int BAW   = ADDR_W - 1;
  localparam int DW    = LANES * BYTE_W;

  cyc_e             bank_cyc  [BANKS];
  logic [DW-1:0]    bank_data [BANKS];
  logic [LANES-1:0] bank_par  [BANKS];
  logic [BANKS-1:0] bank_drv;
  logic [BANKS-1:0] bank_act;

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    localparam logic BSEL = (g != 0);
    sram_ft_bank #(.AW(BAW), .LANES(LANES), .BYTE_W(BYTE_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .ads_n (ads_n),
      .ce_n  (ce_n[g]),
      .sel   (addr[ADDR_W-1] == BSEL),
      .addr  (addr[BAW-1:0]),
      .bw_n  (bw_n),
      .wdata (wdata),
      .wpar  (wpar),
      .cyc   (bank_cyc[g]),
      .rdata (bank_data[g]),
      .rpar  (bank_par[g])
    );
    assign bank_drv[g] = (bank_cyc[g] == CYC_READ) && !oe_n[g];
    assign bank_act[g] = (bank_cyc[g] != CYC_IDLE);
  end

  always_comb begin
    rdata = '0;
    rpar  = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (bank_drv[b]) begin
        rdata = rdata | bank_data[b];
        rpar  = rpar | bank_par[b];
      end
    end
  end

  assign rd_drive = |bank_drv;

  // R9
  one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_act));
  // R4
  write_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_cyc[0] == CYC_WRITE || bank_cyc[1] == CYC_WRITE) |-> !rd_drive);
  // R3
  read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ads_n && !ce_n[0] && !addr[ADDR_W-1] && (&bw_n)) |=> (oe_n[0] || rd_drive));
  // R7
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_drive |-> (rdata == '0 && rpar == '0));
endmodule

// File: tb/sync_ft_sram_test.sv
module sync_ft_sram_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 9;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic        ads_n = 1;
  logic [1:0]  ce_n = 2'b11;
  logic [1:0]  oe_n = 2'b11;
  logic [7:0]  bw_n = 8'hFF;
  logic [63:0] wdata = '0;
  logic [7:0]  wpar = '0;
  logic [63:0] rdata;
  logic [7:0]  rpar;
  logic        rd_drive;

  int checks = 0;
  int errors = 0;

  logic [63:0] ref_d [0:511];
  logic [7:0]  ref_p [0:511];
  logic        m_act = 0;
  logic        m_bank = 0;
  logic [7:0]  m_addr = '0;
  logic        m_wr = 0;
  string       m_tag = "R1";

  sync_ft_sram uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ads_n(ads_n), .ce_n(ce_n),
    .oe_n(oe_n), .bw_n(bw_n), .wdata(wdata), .wpar(wpar),
    .rdata(rdata), .rpar(rpar), .rd_drive(rd_drive)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic model_edge();
    if (!ads_n) begin
      if (!ce_n[addr[8]]) begin
        m_act = 1; m_bank = addr[8]; m_addr = addr[7:0];
        m_tag = (bw_n != 8'hFF) ? "R4" : "R3";
      end else begin
        m_act = 0; m_tag = "R2";
      end
    end else begin
      m_tag = m_act ? "R5" : "R6";
    end
    m_wr = m_act && (bw_n != 8'hFF);
    if (m_wr) begin
      for (int k = 0; k < 8; k++) begin
        if (!bw_n[k]) begin
          ref_d[{m_bank, m_addr}][k*8 +: 8] = wdata[k*8 +: 8];
          ref_p[{m_bank, m_addr}][k] = wpar[k];
        end
      end
    end
  endtask

  task automatic compare(input string tag);
    logic        e_drv;
    logic [63:0] e_d;
    logic [7:0]  e_p;
    e_drv = m_act && !m_wr && !oe_n[m_bank];
    e_d = e_drv ? ref_d[{m_bank, m_addr}] : 64'h0;
    e_p = e_drv ? ref_p[{m_bank, m_addr}] : 8'h0;
    checks++;
    if (rd_drive !== e_drv || rdata !== e_d || rpar !== e_p) begin
      errors++;
      $display("FAIL %s t=%0t drive/data/par actual %b %h %h expected %b %h %h",
               tag, $time, rd_drive, rdata, rpar, e_drv, e_d, e_p);
    end
  endtask

  task automatic step(input logic a_ads, input logic [1:0] a_ce, input logic [AW-1:0] a_addr,
                      input logic [7:0] a_bw, input logic [63:0] a_d, input logic [7:0] a_p,
                      input logic [1:0] a_oe, input string tag);
    @(negedge clk);
    ads_n = a_ads; ce_n = a_ce; addr = a_addr; bw_n = a_bw;
    wdata = a_d; wpar = a_p; oe_n = a_oe;
    @(posedge clk);
    model_edge();
    #1;
    compare(tag == "" ? m_tag : tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; oe_n = 2'b00;
    #1 compare("R1");
    // R1: continue cycles with strobes low after reset write nothing, no drive
    step(1, 2'b00, 9'h000, 8'h00, 64'hDEAD_BEEF_0000_0001, 8'hAA, 2'b00, "R1");
    // preload both banks, addresses 0..15
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < 16; a++)
        step(0, 2'b00, {b[0], 4'h0, a[3:0]}, 8'h00,
             {32'(b * 1000 + a), 32'(a * 7919 + 13)}, 8'(a * 3 + b), 2'b11, "R4");
    // R3 read then R7 oe toggled mid-cycle
    step(0, 2'b10, 9'h005, 8'hFF, 64'h0, 8'h0, 2'b00, "R3");
    #2 oe_n = 2'b11; #1 compare("R7");
    #1 oe_n = 2'b00; #1 compare("R7");
    // R8 write then read next cycle
    step(0, 2'b10, 9'h006, 8'h00, 64'h0123_4567_89AB_CDEF, 8'h5A, 2'b00, "R8");
    step(0, 2'b10, 9'h006, 8'hFF, 64'h0, 8'h0, 2'b00, "R8");
    // R10 only lane 3 written
    step(0, 2'b10, 9'h006, 8'hF7, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 2'b00, "R10");
    step(0, 2'b10, 9'h006, 8'hFF, 64'h0, 8'h0, 2'b00, "R10");
    // R9 same low address, other bank
    step(0, 2'b01, 9'h106, 8'hFF, 64'h0, 8'h0, 2'b00, "R9");
    // R2 enable high deselects
    step(0, 2'b11, 9'h006, 8'h00, 64'h1111, 8'h1, 2'b00, "R2");
    step(0, 2'b10, 9'h006, 8'hFF, 64'h0, 8'h0, 2'b00, "R2");
    // R5 continue ignores addr and enable
    step(1, 2'b11, 9'h10F, 8'hFF, 64'h0, 8'h0, 2'b00, "R5");
    step(1, 2'b11, 9'h10F, 8'h7F, 64'hAB00_0000_0000_0000, 8'h80, 2'b00, "R5");
    step(1, 2'b11, 9'h10F, 8'hFF, 64'h0, 8'h0, 2'b00, "R5");
    // R1 reset mid-run keeps memory
    @(negedge clk); rst_n = 0;
    @(posedge clk); m_act = 0; m_wr = 0; #1 compare("R1");
    @(negedge clk); rst_n = 1;
    step(1, 2'b00, 9'h000, 8'h00, 64'h5555, 8'h55, 2'b00, "R1");
    step(0, 2'b10, 9'h000, 8'hFF, 64'h0, 8'h0, 2'b00, "R1");
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] bw;
      bw = ($urandom % 2) ? 8'hFF : 8'($urandom);
      step(1'($urandom % 3 == 0), 2'($urandom), {1'($urandom), 4'h0, 4'($urandom)}, bw,
           {$urandom, $urandom}, 8'($urandom), 2'($urandom), "");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired, actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule